// File: doc/BRIEF.md
# Dual-Channel Digital Lock Indicator

This block watches two frequency-synthesis loops and reports on one open-drain status pin whether they are in lock. It runs on the reference-oscillator clock. For each channel it takes the pulse train from the reference divider and the pulse train from the channel divider, and measures how many oscillator cycles separate their rising edges. A comparison whose two edges land less than two oscillator cycles apart counts as in-window. A channel is reported locked only after a run of in-window comparisons longer than three. A single bad comparison removes the indication at once.

The pin is driven through a selector. In normal operation it shows a constant low, either channel's lock indication, or both indications combined. A channel held in standby always reports itself as locked. In test mode the same pin carries raw internal signals instead: prescaler taps, channel-divider pulses, the reference pulse, and oscillator divided by two or four. The output is an active-low pull-down enable, so a 0 pulls the pin low and a 1 releases it to the external pull-up.

Top module: `pll_lock_indicator`

## Requirements
- R1: A comparison is in-window when the rising edges of a channel's reference pulse and divider pulse are sampled on the same oscillator cycle or one cycle apart, in either order.
- R2: A comparison is out-of-window when the second edge arrives two or more cycles after the first. A second edge on the same input before its partner arrives also counts as out-of-window.
- R3: A channel's lock indication rises on the clock edge that completes the fourth consecutive in-window comparison, and not on any earlier one.
- R4: An out-of-window comparison clears the lock indication on the same clock edge that completes it and restarts the run count from zero. The indication holds unchanged while a comparison is still open.
- R5: A channel whose standby bit is set (stby[0] for channel 1, stby[1] for channel 2) reports its indication as 1. Its detector is cleared, so after standby is released the indication is 0 until four new in-window comparisons have completed.
- R6: With test_en=0, lock_sel picks the pin level: 2'b00 gives 0, 2'b01 gives the channel 2 indication, 2'b10 gives the channel 1 indication, and 2'b11 gives the AND of both.
- R7: With test_en=1 and stby=2'b01, lock_sel picks: 2'b00 gives 0, 2'b01 gives pres_tap[1], 2'b10 gives chan_pulse[1], and 2'b11 gives ref_pulse[0].
- R8: With test_en=1 and stby=2'b10, lock_sel picks: 2'b00 gives the divide-by-four signal, 2'b01 gives pres_tap[0], 2'b10 gives chan_pulse[0], and 2'b11 gives the divide-by-two signal. With test_en=1 and stby equal to 2'b00 or 2'b11, the pin is 0.
- R9: The divide-by-two signal toggles on every oscillator clock edge. The divide-by-four signal toggles on every second edge.
- R10: After reset both lock indications are 0 and both detectors hold no open comparison.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Reference-oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_pulse | input | 2 | Reference-divider pulse per channel (bit 0 = channel 1) |
| chan_pulse | input | 2 | Channel-divider pulse per channel |
| pres_tap | input | 2 | Prescaler output per channel, for test routing |
| stby | input | 2 | Standby bit per channel |
| test_en | input | 1 | 1 selects test routing of the pin |
| lock_sel | input | 2 | Pin source select |
| ld_pd_n | output | 1 | Active-low pull-down enable of the lock pin |

## Verification
If the run counter is off by one, the pin rises one comparison too early or too late, on the clock edge that closes the fourth in-window pair. The bench checks one pair before that edge and at that edge. If an open-comparison state is left stale, the next pair that should pass is reported as out-of-window, which shows at the pin within one reference period. If the elapsed-cycle count saturates at the wrong value, a skew of exactly two cycles is wrongly accepted. That error shows on the edge that completes the late pair. Selector and divider faults appear combinationally, or within two oscillator cycles, in test mode.

// File: rtl/lkd_pkg.sv
`timescale 1ns/1ps
package lkd_pkg;

  localparam int unsigned LKD_NCH = 2;

  // open-comparison state of one skew meter
  typedef enum logic [1:0] {
    SK_IDLE = 2'b00,
    SK_WREF = 2'b01,   // divider edge seen, waiting for reference edge
    SK_WCHN = 2'b10    // reference edge seen, waiting for divider edge
  } skew_st_e;

  // test-mode routing group, taken from the standby bits {ch2, ch1}
  typedef enum logic [1:0] {
    TG_OFF  = 2'b00,
    TG_CH2  = 2'b01,
    TG_CH1  = 2'b10,
    TG_BOTH = 2'b11
  } tgrp_e;

  // skew in oscillator cycles is acceptable when strictly below the window
  function automatic logic gap_inside(input int unsigned gap, input int unsigned win);
    return gap < win;
  endfunction

  // the run of good comparisons is complete when the count sits at the limit
  function automatic logic run_full(input int unsigned cnt, input int unsigned limit);
    return cnt >= limit;
  endfunction

  // normal-mode pin source
  function automatic logic norm_pick(input logic [1:0] sel, input logic ind1, input logic ind2);
    case (sel)
      2'b00:   return 1'b0;
      2'b01:   return ind2;
      2'b10:   return ind1;
      default: return ind1 & ind2;
    endcase
  endfunction

endpackage

// File: rtl/lkd_skew_meas.sv
`timescale 1ns/1ps
module lkd_skew_meas
  import lkd_pkg::*;
#(
  parameter int unsigned WIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ref_in,
  input  logic chn_in,
  output logic good_o,
  output logic bad_o
);

  localparam int unsigned    EW    = $clog2(WIN + 1);
  localparam logic [EW-1:0]  E_MAX = EW'(WIN);
  localparam logic [EW-1:0]  E_ONE = EW'(1);

  logic          ref_d, chn_d;
  logic          ref_rise, chn_rise;
  skew_st_e      st_q, st_d;
  logic [EW-1:0] e_q, e_d;
  logic          hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_d <= 1'b0;
      chn_d <= 1'b0;
      st_q  <= SK_IDLE;
      e_q   <= '0;
    end else begin
      ref_d <= ref_in;
      chn_d <= chn_in;
      st_q  <= st_d;
      e_q   <= e_d;
    end
  end

  assign ref_rise = ref_in & ~ref_d;
  assign chn_rise = chn_in & ~chn_d;
  assign hit      = gap_inside(32'(e_q), WIN);

  always_comb begin
    st_d   = st_q;
    e_d    = e_q;
    good_o = 1'b0;
    bad_o  = 1'b0;
    if (clr) begin
      st_d = SK_IDLE;
      e_d  = '0;
    end else begin
      case (st_q)
        SK_IDLE: begin
          if (ref_rise && chn_rise) begin
            good_o = 1'b1;
          end else if (ref_rise) begin
            st_d = SK_WCHN;
            e_d  = E_ONE;
          end else if (chn_rise) begin
            st_d = SK_WREF;
            e_d  = E_ONE;
          end
        end
        SK_WCHN: begin
          if (chn_rise) begin
            good_o = hit;
            bad_o  = ~hit;
            if (ref_rise) e_d = E_ONE;
            else          st_d = SK_IDLE;
          end else if (ref_rise) begin
            bad_o = 1'b1;
            e_d   = E_ONE;
          end else if (e_q != E_MAX) begin
            e_d = e_q + E_ONE;
          end
        end
        SK_WREF: begin
          if (ref_rise) begin
            good_o = hit;
            bad_o  = ~hit;
            if (chn_rise) e_d = E_ONE;
            else          st_d = SK_IDLE;
          end else if (chn_rise) begin
            bad_o = 1'b1;
            e_d   = E_ONE;
          end else if (e_q != E_MAX) begin
            e_d = e_q + E_ONE;
          end
        end
        default: begin
          st_d = SK_IDLE;
          e_d  = '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/lkd_lock_qual.sv
`timescale 1ns/1ps
module lkd_lock_qual
  import lkd_pkg::*;
#(
  parameter int unsigned QUAL = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic good,
  input  logic bad,
  output logic lock_o
);

  localparam int unsigned   QW    = $clog2(QUAL + 1);
  localparam logic [QW-1:0] Q_ONE = QW'(1);

  logic [QW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      lock_o <= 1'b0;
    end else if (clr || bad) begin
      run_q  <= '0;
      lock_o <= 1'b0;
    end else if (good) begin
      if (run_full(32'(run_q), QUAL)) lock_o <= 1'b1;
      else                            run_q  <= run_q + Q_ONE;
    end
  end

endmodule

// File: rtl/lkd_rate_div.sv
`timescale 1ns/1ps
module lkd_rate_div (
  input  logic clk,
  input  logic rst_n,
  output logic half_o,
  output logic quarter_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_o    <= 1'b0;
      quarter_o <= 1'b0;
    end else begin
      half_o <= ~half_o;
      if (half_o) quarter_o <= ~quarter_o;
    end
  end

endmodule

// File: rtl/lkd_out_sel.sv
`timescale 1ns/1ps
module lkd_out_sel
  import lkd_pkg::*;
(
  input  logic       test_en,
  input  logic [1:0] stby,
  input  logic [1:0] lock_sel,
  input  logic [1:0] ind,
  input  logic [1:0] pres,
  input  logic [1:0] chan,
  input  logic       fref,
  input  logic       half,
  input  logic       quarter,
  output logic       level
);

  tgrp_e grp;
  assign grp = tgrp_e'(stby);

  always_comb begin
    level = 1'b0;
    if (!test_en) begin
      level = norm_pick(lock_sel, ind[0], ind[1]);
    end else begin
      case (grp)
        TG_CH2: begin
          case (lock_sel)
            2'b01:   level = pres[1];
            2'b10:   level = chan[1];
            2'b11:   level = fref;
            default: level = 1'b0;
          endcase
        end
        TG_CH1: begin
          case (lock_sel)
            2'b00:   level = quarter;
            2'b01:   level = pres[0];
            2'b10:   level = chan[0];
            default: level = half;
          endcase
        end
        default: level = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/pll_lock_indicator.sv
`timescale 1ns/1ps
module pll_lock_indicator
  import lkd_pkg::*;
#(
  parameter int unsigned SKEW_WIN  = 2,
  parameter int unsigned QUAL_RUNS = 3
) (
  input  logic               clk_osc,
  input  logic               rst_n,
  input  logic [LKD_NCH-1:0] ref_pulse,
  input  logic [LKD_NCH-1:0] chan_pulse,
  input  logic [LKD_NCH-1:0] pres_tap,
  input  logic [LKD_NCH-1:0] stby,
  input  logic               test_en,
  input  logic [1:0]         lock_sel,
  output logic               ld_pd_n
);

  // named internal events, observed by the bound checker
  logic [LKD_NCH-1:0] good_evt;
  logic [LKD_NCH-1:0] bad_evt;
  logic [LKD_NCH-1:0] lock_q;
  logic [LKD_NCH-1:0] chan_ind;
  logic               half_clk;
  logic               quarter_clk;

  for (genvar gi = 0; gi < LKD_NCH; gi++) begin : g_ch
    lkd_skew_meas #(.WIN(SKEW_WIN)) u_skew (
      .clk    (clk_osc),
      .rst_n  (rst_n),
      .clr    (stby[gi]),
      .ref_in (ref_pulse[gi]),
      .chn_in (chan_pulse[gi]),
      .good_o (good_evt[gi]),
      .bad_o  (bad_evt[gi])
    );

    lkd_lock_qual #(.QUAL(QUAL_RUNS)) u_qual (
      .clk    (clk_osc),
      .rst_n  (rst_n),
      .clr    (stby[gi]),
      .good   (good_evt[gi]),
      .bad    (bad_evt[gi]),
      .lock_o (lock_q[gi])
    );

    assign chan_ind[gi] = stby[gi] | lock_q[gi];
  end

  lkd_rate_div u_div (
    .clk       (clk_osc),
    .rst_n     (rst_n),
    .half_o    (half_clk),
    .quarter_o (quarter_clk)
  );

  lkd_out_sel u_sel (
    .test_en  (test_en),
    .stby     (stby),
    .lock_sel (lock_sel),
    .ind      (chan_ind),
    .pres     (pres_tap),
    .chan     (chan_pulse),
    .fref     (ref_pulse[0]),
    .half     (half_clk),
    .quarter  (quarter_clk),
    .level    (ld_pd_n)
  );

endmodule

// File: rtl/lkd_checker.sv
`timescale 1ns/1ps
module lkd_checker (
  input logic       clk_osc,
  input logic       rst_n,
  input logic       test_en,
  input logic [1:0] stby,
  input logic [1:0] lock_sel,
  input logic       ld_pd_n,
  input logic [1:0] good_evt,
  input logic [1:0] bad_evt,
  input logic [1:0] lock_q,
  input logic       half_clk
);

  logic past_ok;
  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R3: lock only rises right after an in-window comparison
  assert_lock_after_good_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (past_ok && $rose(lock_q[0])) |-> $past(good_evt[0]));
  assert_lock_after_good_ch2_R3: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (past_ok && $rose(lock_q[1])) |-> $past(good_evt[1]));

  // R4: an out-of-window comparison clears the indication on the next edge
  assert_bad_drops_R4: assert property (@(posedge clk_osc) disable iff (!rst_n)
    bad_evt[0] |=> !lock_q[0]);
  assert_bad_drops_ch2_R4: assert property (@(posedge clk_osc) disable iff (!rst_n)
    bad_evt[1] |=> !lock_q[1]);

  // R2: one comparison is never judged both ways
  assert_evt_single_R2: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $onehot0({good_evt[0], bad_evt[0]}));

  // R5: standby channel reads high when selected
  assert_stby_high_R5: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (!test_en && lock_sel == 2'b10 && stby[0]) |-> ld_pd_n);

  // R6: constant-low selection
  assert_sel_low_R6: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (!test_en && lock_sel == 2'b00) |-> !ld_pd_n);

  // R8: test mode without a routing group keeps the pin low
  assert_test_off_R8: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (test_en && (stby == 2'b00 || stby == 2'b11)) |-> !ld_pd_n);

  // R9: divide-by-two toggles on every edge
  assert_half_toggle_R9: assert property (@(posedge clk_osc) disable iff (!rst_n)
    past_ok |-> (half_clk != $past(half_clk)));

endmodule

bind pll_lock_indicator lkd_checker u_chk (
  .clk_osc  (clk_osc),
  .rst_n    (rst_n),
  .test_en  (test_en),
  .stby     (stby),
  .lock_sel (lock_sel),
  .ld_pd_n  (ld_pd_n),
  .good_evt (good_evt),
  .bad_evt  (bad_evt),
  .lock_q   (lock_q),
  .half_clk (half_clk)
);

// File: tb/sim_pll_lock_indicator.sv
`timescale 1ns/1ps
module sim_pll_lock_indicator;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] refp = '0, chp = '0, pres = '0, stby = '0;
  logic       test_en = 1'b0;
  logic [1:0] lsel = '0;
  logic       pd_n;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  pll_lock_indicator u0 (
    .clk_osc    (clk),
    .rst_n      (rst_n),
    .ref_pulse  (refp),
    .chan_pulse (chp),
    .pres_tap   (pres),
    .stby       (stby),
    .test_en    (test_en),
    .lock_sel   (lsel),
    .ld_pd_n    (pd_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // one comparison: reference edge at slot 3, divider edge at slot 3+dly
  task automatic pair(input int ch, input int dly);
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      refp[ch] = (t == 3);
      chp[ch]  = (t == 3 + dly);
    end
    @(negedge clk);
    refp[ch] = 1'b0;
    chp[ch]  = 1'b0;
  endtask

  task automatic lock_ch(input int ch);
    for (int k = 0; k < 4; k++) pair(ch, 0);
  endtask

  task automatic clear_ch(input int ch);
    stby[ch] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    stby[ch] = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    lsel = 2'b10; #1 chk("R10 ch1 after reset", pd_n, 1'b0);
    lsel = 2'b01; #1 chk("R10 ch2 after reset", pd_n, 1'b0);
    lsel = 2'b11; #1 chk("R10 both after reset", pd_n, 1'b0);
  endtask

  task automatic t_qualify;
    lsel = 2'b10;
    pair(0, 0);  chk("R3 one good", pd_n, 1'b0);
    pair(0, 1);  chk("R3 two good (R1 lag 1)", pd_n, 1'b0);
    pair(0, -1); chk("R3 three good (R1 lead 1)", pd_n, 1'b0);
    pair(0, 0);  chk("R3 fourth good locks", pd_n, 1'b1);
    pair(0, 1);  chk("R1 lag 1 keeps lock", pd_n, 1'b1);
  endtask

  task automatic t_drop_now;
    @(negedge clk); refp[0] = 1'b1;
    @(negedge clk); refp[0] = 1'b0; chk("R4 held while open", pd_n, 1'b1);
    @(negedge clk); chk("R4 held at gap 2", pd_n, 1'b1); chp[0] = 1'b1;
    @(negedge clk); chp[0] = 1'b0; chk("R2 lag 2 drops at once", pd_n, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_recount;
    for (int k = 0; k < 3; k++) begin
      pair(0, 0); chk("R4 recount not yet", pd_n, 1'b0);
    end
    pair(0, 0); chk("R4 recount fourth locks", pd_n, 1'b1);
  endtask

  task automatic t_lead_bad;
    pair(0, -2); chk("R2 lead 2 drops", pd_n, 1'b0);
    lock_ch(0);  chk("R4 relock after lead", pd_n, 1'b1);
  endtask

  task automatic t_missing;
    @(negedge clk); refp[0] = 1'b1;
    @(negedge clk); refp[0] = 1'b0;
    repeat (3) @(negedge clk);
    refp[0] = 1'b1;
    @(negedge clk); refp[0] = 1'b0;
    chk("R2 repeated reference edge drops", pd_n, 1'b0);
    clear_ch(0);
    lock_ch(0); chk("R2 relock after clear", pd_n, 1'b1);
  endtask

  task automatic t_standby;
    stby[0] = 1'b1; #1 chk("R5 standby reads high", pd_n, 1'b1);
    pair(0, 3); chk("R5 standby ignores bad pair", pd_n, 1'b1);
    stby[0] = 1'b0; #1 chk("R5 released detector cleared", pd_n, 1'b0);
    for (int k = 0; k < 3; k++) pair(0, 0);
    chk("R5 three after release", pd_n, 1'b0);
    pair(0, 0); chk("R5 fourth after release", pd_n, 1'b1);
  endtask

  task automatic t_normal_mux;
    lsel = 2'b11; #1 chk("R6 and, ch2 unlocked", pd_n, 1'b0);
    lsel = 2'b01; #1 chk("R6 ch2 unlocked", pd_n, 1'b0);
    lsel = 2'b10; #1 chk("R6 ch1 locked", pd_n, 1'b1);
    lsel = 2'b00; #1 chk("R6 low with ch1 locked", pd_n, 1'b0);
    lock_ch(1);
    lsel = 2'b11; #1 chk("R6 and both locked", pd_n, 1'b1);
    lsel = 2'b01; #1 chk("R6 ch2 locked", pd_n, 1'b1);
    lsel = 2'b00; #1 chk("R6 low with both locked", pd_n, 1'b0);
    stby[1] = 1'b1;
    pair(0, 3);
    lsel = 2'b11; #1 chk("R6 and ch1 dropped", pd_n, 1'b0);
    lsel = 2'b01; #1 chk("R5 ch2 standby high", pd_n, 1'b1);
    stby[1] = 1'b0; #1 chk("R5 ch2 released cleared", pd_n, 1'b0);
  endtask

  task automatic t_test_ch2;
    test_en = 1'b1; stby = 2'b01;
    lsel = 2'b01; pres[1] = 1'b1; #1 chk("R7 prescaler 2 high", pd_n, 1'b1);
    pres[1] = 1'b0; #1 chk("R7 prescaler 2 low", pd_n, 1'b0);
    lsel = 2'b10; chp[1] = 1'b1; #1 chk("R7 divider 2 high", pd_n, 1'b1);
    chp[1] = 1'b0; #1 chk("R7 divider 2 low", pd_n, 1'b0);
    lsel = 2'b11; refp[0] = 1'b1; #1 chk("R7 reference high", pd_n, 1'b1);
    refp[0] = 1'b0; #1 chk("R7 reference low", pd_n, 1'b0);
    lsel = 2'b00; pres = 2'b11; chp = 2'b11; refp = 2'b11;
    #1 chk("R7 slot 00 low", pd_n, 1'b0);
    pres = '0; chp = '0; refp = '0;
  endtask

  task automatic t_test_ch1;
    logic prev;
    int   flips;
    test_en = 1'b1; stby = 2'b10;
    lsel = 2'b01; pres[0] = 1'b1; #1 chk("R8 prescaler 1 high", pd_n, 1'b1);
    pres[0] = 1'b0; #1 chk("R8 prescaler 1 low", pd_n, 1'b0);
    lsel = 2'b10; chp[0] = 1'b1; #1 chk("R8 divider 1 high", pd_n, 1'b1);
    chp[0] = 1'b0; #1 chk("R8 divider 1 low", pd_n, 1'b0);
    lsel = 2'b11;
    @(negedge clk); prev = pd_n;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R9 half toggles each cycle", pd_n, ~prev);
      prev = pd_n;
    end
    lsel = 2'b00;
    @(negedge clk); prev = pd_n; flips = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (pd_n !== prev) flips++;
      prev = pd_n;
    end
    chk("R9 quarter toggles every second cycle", flips == 4, 1'b1);
    lsel = 2'b01; pres[0] = 1'b1;
    stby = 2'b00; #1 chk("R8 no group low", pd_n, 1'b0);
    stby = 2'b11; #1 chk("R8 both groups low", pd_n, 1'b0);
    pres = '0; test_en = 1'b0; stby = '0; lsel = 2'b00;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_qualify();
    t_drop_now();
    t_recount();
    t_lead_bad();
    t_missing();
    t_standby();
    t_normal_mux();
    t_test_ch2();
    t_test_ch1();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL all: watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule